// File: doc/BRIEF.md
# Page-Write EEPROM Controller Model

This block is a cycle-level model of the write engine found inside a byte-wide parallel EEPROM. A host reaches it through a plain synchronous bus. The bus carries an address, write data, a write strobe, a read strobe, registered read data and an active-low reset. The host writes a burst of bytes that all belong to one page. The engine collects them in a page buffer. When the strobes have been idle long enough, it closes the load and starts a timed internal programming phase. At the end of that phase it commits the buffered bytes to the storage array in a single cycle.

While programming runs, a busy output is held low. Reads in that phase return a polling status byte instead of array data. Bit 7 of that byte is the complement of the most recently loaded byte's bit 7. Bit 6 alternates on each status read. The byte-load window, the load-close delay and the programming time are parameters counted in clock cycles. Short values suit simulation and long values model the real device. The array depth is also a parameter: ADDR_W = 15 gives the full 32K x 8 arrangement, and the default is smaller.

Top module: `ee_page_writer`

## Requirements
- R1: While rst_n is low, busy_n is 1, rdata is 0, and write strobes start no load. After rst_n rises, rdata stays 0 until the first read, and busy_n stays 1 until a load closes.
- R2: Address bits ADDR_W-1..6 select the page and bits 5..0 select the byte slot. The page is taken from the first write of a load. Later writes in that load use only bits 5..0 and land in the captured page.
- R3: A later write joins the load only if its strobe edge comes at most T_WIN clock edges after the previous accepted write. A write that comes later than that is dropped and changes no array byte.
- R4: Counting from the edge of the last accepted write, busy_n goes to 0 right after edge T_CLOSE.
- R5: busy_n stays 0 for exactly T_PROG cycles and returns to 1 after edge T_CLOSE+T_PROG. At that point the loaded bytes are visible in the array.
- R6: At commit, only the slots written during the load are updated. Every other byte of the page keeps its old value. If a slot is written twice, the later value is the one stored.
- R7: A read while busy returns a status byte one cycle later. In that byte, bit 7 is the inverse of bit 7 of the last loaded byte, and bits 5..0 equal bits 5..0 of that byte.
- R8: In the status byte, bit 6 is 1 on the first read of each programming phase and flips on every further read in that phase.
- R9: Write strobes while busy are ignored. They change no array byte and do not lengthen the busy time.
- R10: Pulling rst_n low while busy aborts programming. busy_n returns to 1 and no byte of the pending page is written.
- R11: A read when not busy (idle or loading) returns the array byte at addr on the next cycle. If wr_en and rd_en are both high in one cycle, the write is taken and the read is dropped, so rdata keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset; blocks access and aborts programming |
| addr | input | ADDR_W | Byte address: page in the high bits, slot in the low 6 bits |
| wdata | input | 8 | Byte to load |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data or polling status byte |
| busy_n | output | 1 | Low during internal programming |

## Verification
Two functions can meet in the same cycle. The first meeting is between a write strobe and the edge on which the byte-load window runs out. The bench places one write exactly T_WIN edges after the previous one, and it must join the load. It places the next write one edge past the window, and that write must leave its slot unchanged. The same directed case also checks that the late write does not restart the close timer. The second meeting is between a read strobe and the commit or abort of programming. Random bursts issue status reads inside the busy window and then read back every slot of the page. In the abort case, reset lands during the busy window and the bench confirms that no pending byte reached the array.

// File: rtl/ee_pkg.sv
package ee_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } eng_state_e;

  // polling status byte: inverted MSB, alternating bit 6, rest passed through
  function automatic logic [7:0] poll_byte(input logic [7:0] last, input logic tog);
    return {~last[7], tog, last[5:0]};
  endfunction
endpackage

// File: rtl/ee_seq.sv
module ee_seq import ee_pkg::*; #(
  parameter int T_WIN   = 8,
  parameter int T_CLOSE = 20,
  parameter int T_PROG  = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  output eng_state_e state_q,
  output logic       load_first,
  output logic       load_more,
  output logic       commit,
  output logic       poll_rd,
  output logic       arr_rd,
  output logic       poll_tog
);
  localparam int IW = $clog2(T_CLOSE + 1);
  localparam int PW = $clog2(T_PROG + 1);

  logic [IW-1:0] idle_q;
  logic [PW-1:0] prog_q;
  logic          win_open;
  logic          close_hit;

  assign win_open   = (idle_q < IW'(T_WIN));
  assign load_first = (state_q == ST_IDLE) && wr_en;
  assign load_more  = (state_q == ST_LOAD) && wr_en && win_open;
  assign close_hit  = (state_q == ST_LOAD) && !load_more && (idle_q == IW'(T_CLOSE - 1));
  assign commit     = (state_q == ST_PROG) && (prog_q == PW'(T_PROG - 1));
  assign poll_rd    = (state_q == ST_PROG) && rd_en && !wr_en;
  assign arr_rd     = (state_q != ST_PROG) && rd_en && !wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idle_q   <= '0;
      prog_q   <= '0;
      poll_tog <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (load_first) begin
            state_q <= ST_LOAD;
            idle_q  <= '0;
          end
        end
        ST_LOAD: begin
          if (load_more) begin
            idle_q <= '0;
          end else if (close_hit) begin
            state_q  <= ST_PROG;
            prog_q   <= '0;
            poll_tog <= 1'b1;
          end else begin
            idle_q <= idle_q + 1'b1;
          end
        end
        ST_PROG: begin
          if (commit) state_q <= ST_IDLE;
          else        prog_q  <= prog_q + 1'b1;
          if (poll_rd) poll_tog <= ~poll_tog;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_CLOSE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_PROG) |-> $past(idle_q) == IW'(T_CLOSE - 1)); // R4
  AST_PROG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PROG && !commit) |=> state_q == ST_PROG); // R5
  AST_COMMIT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> state_q == ST_IDLE); // R5
  AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_rd && !commit) |=> poll_tog != $past(poll_tog)); // R8
endmodule

// File: rtl/ee_page_buf.sv
module ee_page_buf #(
  parameter int ADDR_W = 11,
  parameter int OFF_W  = 6,
  localparam int NB    = 1 << OFF_W,
  localparam int PG_W  = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_first,
  input  logic              load_more,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [PG_W-1:0]   page_q,
  output logic [NB*8-1:0]   bytes_q,
  output logic [NB-1:0]     mask_q,
  output logic [7:0]        last_q
);
  logic [7:0]       slot_q [NB];
  logic [NB-1:0]    hit;
  logic [OFF_W-1:0] off;

  assign off = addr[OFF_W-1:0];

  always_comb begin
    for (int i = 0; i < NB; i++)
      hit[i] = (load_first || load_more) && (off == OFF_W'(i));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NB; i++)
      if (hit[i]) slot_q[i] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      page_q <= '0;
      last_q <= '0;
    end else if (load_first) begin
      mask_q <= hit;
      page_q <= addr[ADDR_W-1:OFF_W];
      last_q <= wdata;
    end else if (load_more) begin
      mask_q <= mask_q | hit;
      last_q <= wdata;
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_pack
    assign bytes_q[g*8 +: 8] = slot_q[g];
  end

  AST_FIRST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    load_first |=> $countones(mask_q) == 1); // R2
  AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mask_q) && $stable(last_q) && $stable(page_q)); // R9
endmodule

// File: rtl/ee_array.sv
module ee_array #(
  parameter int ADDR_W = 11,
  parameter int OFF_W  = 6,
  localparam int NB    = 1 << OFF_W,
  localparam int PG_W  = ADDR_W - OFF_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [PG_W-1:0]   page,
  input  logic [NB*8-1:0]   bytes,
  input  logic [NB-1:0]     mask,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rd_byte
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < NB; i++)
        if (mask[i]) mem[{page, OFF_W'(i)}] <= bytes[i*8 +: 8];
    end
  end

  assign rd_byte = mem[raddr];

  AST_COMMIT_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> mask != '0); // R6
endmodule

// File: rtl/ee_page_writer.sv
module ee_page_writer import ee_pkg::*; #(
  parameter int ADDR_W     = 11,
  parameter int PAGE_OFF_W = 6,
  parameter int T_WIN      = 8,
  parameter int T_CLOSE    = 20,
  parameter int T_PROG     = 40,
  localparam int NB        = 1 << PAGE_OFF_W,
  localparam int PG_W      = ADDR_W - PAGE_OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [7:0]        rdata,
  output logic              busy_n
);
  eng_state_e        state_q;
  logic              load_first, load_more, commit, poll_rd, arr_rd, poll_tog;
  logic [PG_W-1:0]   page_q;
  logic [NB*8-1:0]   bytes_q;
  logic [NB-1:0]     mask_q;
  logic [7:0]        last_q;
  logic [7:0]        arr_byte;
  logic              busy;

  assign busy   = (state_q == ST_PROG);
  assign busy_n = ~busy;

  ee_seq #(.T_WIN(T_WIN), .T_CLOSE(T_CLOSE), .T_PROG(T_PROG)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .state_q(state_q), .load_first(load_first), .load_more(load_more),
    .commit(commit), .poll_rd(poll_rd), .arr_rd(arr_rd), .poll_tog(poll_tog)
  );

  ee_page_buf #(.ADDR_W(ADDR_W), .OFF_W(PAGE_OFF_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .load_first(load_first), .load_more(load_more),
    .busy(busy), .addr(addr), .wdata(wdata),
    .page_q(page_q), .bytes_q(bytes_q), .mask_q(mask_q), .last_q(last_q)
  );

  ee_array #(.ADDR_W(ADDR_W), .OFF_W(PAGE_OFF_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .commit(commit), .page(page_q), .bytes(bytes_q),
    .mask(mask_q), .raddr(addr), .rd_byte(arr_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata <= '0;
    else if (poll_rd) rdata <= poll_byte(last_q, poll_tog);
    else if (arr_rd)  rdata <= arr_byte;
  end

  AST_POLL_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    poll_rd |=> rdata[7] == ~$past(last_q[7])); // R7
  AST_POLL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    poll_rd |=> rdata[5:0] == $past(last_q[5:0])); // R7
  AST_BOTH_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en) |=> $stable(rdata)); // R11
endmodule

// File: tb/sim_ee_page_writer.sv
module sim_ee_page_writer;
  localparam int AW = 11, OW = 6, TW = 8, TC = 20, TP = 40;
  localparam int DEPTH = 1 << AW, NB = 1 << OW, NPG = DEPTH / NB;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  wire  [7:0] rdata;
  wire        busy_n;

  always #10 clk = ~clk;

  ee_page_writer #(.ADDR_W(AW), .PAGE_OFF_W(OW), .T_WIN(TW), .T_CLOSE(TC), .T_PROG(TP)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .busy_n(busy_n)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] mem_m [DEPTH];
  bit known_m [DEPTH];

  function automatic logic [AW-1:0] mk(input int pg, input int off);
    return AW'((pg << OW) | off);
  endfunction

  function automatic logic [7:0] status_exp(input logic [7:0] last, input int nth);
    return {~last[7], (nth % 2 == 0), last[5:0]};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic check_known(input string req, input int a);
    logic [7:0] v;
    if (known_m[a]) begin
      rd(AW'(a), v);
      chk(req, v, mem_m[a]);
    end
  endtask

  task automatic fill_page(input int pg, input logic [7:0] base);
    for (int i = 0; i < NB; i++) wr(mk(pg, i), base + 8'(i * 3));
    idle(TC + TP);
    chk("R5 busy released after fill", {7'd0, busy_n}, 8'd1);
    for (int i = 0; i < NB; i++) begin
      mem_m[(pg << OW) | i] = base + 8'(i * 3);
      known_m[(pg << OW) | i] = 1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v1, last;
    logic [7:0] pd [NB];
    bit pm [NB];
    int pg, n, off;
    logic [AW-1:0] a;
    void'($urandom(32'd1234));
    foreach (known_m[i]) known_m[i] = 0;

    // R1: reset state and blocked access
    @(negedge clk);
    chk("R1 busy_n in reset", {7'd0, busy_n}, 8'd1);
    chk("R1 rdata in reset", rdata, 8'd0);
    wr(mk(1, 1), 8'h77);
    rd(mk(1, 1), v);
    chk("R1 read blocked in reset", v, 8'd0);
    rst_n = 1'b1;
    idle(TC + 2);
    chk("R1 no load from write in reset", {7'd0, busy_n}, 8'd1);
    chk("R1 rdata after release", rdata, 8'd0);

    fill_page(0, 8'h11);
    fill_page(1, 8'h40);
    fill_page(2, 8'h83);
    fill_page(3, 8'hC5);
    fill_page(4, 8'h29);

    // R3: write at window edge joins; one edge later is dropped
    wr(mk(1, 3), 8'hA1);
    idle(TW - 1);
    wr(mk(1, 4), 8'hA2);
    idle(TW);
    wr(mk(1, 5), 8'hA3);
    idle(TC - TW - 2);
    chk("R4 not busy before close (late write)", {7'd0, busy_n}, 8'd1);
    idle(1);
    chk("R4 busy at close (late write)", {7'd0, busy_n}, 8'd0);
    idle(TP);
    mem_m[(1 << OW) | 3] = 8'hA1; mem_m[(1 << OW) | 4] = 8'hA2;
    check_known("R3 first byte", (1 << OW) | 3);
    check_known("R3 byte at window edge", (1 << OW) | 4);
    check_known("R3 late byte dropped", (1 << OW) | 5);

    // R2/R6/R9: page capture, rewrite of a slot, writes while busy
    wr(mk(2, 7), 8'hB1);
    wr(mk(3, 9), 8'hB2);
    wr(mk(2, 10), 8'hC1);
    wr(mk(2, 10), 8'hC2);
    idle(TC);
    chk("R4 busy after close", {7'd0, busy_n}, 8'd0);
    wr(mk(2, 20), 8'hDD);
    idle(TP - 2);
    chk("R9 busy not extended (still busy)", {7'd0, busy_n}, 8'd0);
    idle(1);
    chk("R9 busy ends on time", {7'd0, busy_n}, 8'd1);
    mem_m[(2 << OW) | 7] = 8'hB1; mem_m[(2 << OW) | 9] = 8'hB2; mem_m[(2 << OW) | 10] = 8'hC2;
    check_known("R2 first write page", (2 << OW) | 7);
    check_known("R2 later write follows captured page", (2 << OW) | 9);
    check_known("R2 other page untouched", (3 << OW) | 9);
    check_known("R6 slot rewritten keeps last", (2 << OW) | 10);
    check_known("R9 write while busy ignored", (2 << OW) | 20);
    check_known("R6 unloaded slot kept", (2 << OW) | 11);

    // R10: abort during programming
    wr(mk(4, 0), 8'hE0);
    wr(mk(4, 1), 8'hE1);
    idle(TC + 5);
    chk("R10 busy before abort", {7'd0, busy_n}, 8'd0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 busy released by abort", {7'd0, busy_n}, 8'd1);
    wr(mk(4, 2), 8'hE2);
    rd(mk(4, 0), v);
    chk("R1 read blocked during abort reset", v, 8'd0);
    rst_n = 1'b1;
    idle(TC + TP + 2);
    chk("R1 write in reset started nothing", {7'd0, busy_n}, 8'd1);
    check_known("R10 aborted slot 0 unchanged", (4 << OW) | 0);
    check_known("R10 aborted slot 1 unchanged", (4 << OW) | 1);
    check_known("R1 slot written in reset unchanged", (4 << OW) | 2);

    // R11: simultaneous strobes, read during load
    rd(mk(0, 5), v1);
    chk("R11 plain read", v1, mem_m[5]);
    addr = mk(0, 6); wdata = 8'h5E; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R11 read dropped with write", rdata, v1);
    rd(mk(0, 6), v);
    chk("R11 read during load gives old byte", v, mem_m[6]);
    idle(TC + TP - 1);
    chk("R5 busy released after load", {7'd0, busy_n}, 8'd1);
    mem_m[6] = 8'h5E;
    check_known("R11 write taken with both strobes", 6);

    // random bursts with status polling
    for (int it = 0; it < 24; it++) begin
      pg = $urandom_range(0, NPG - 1);
      n = $urandom_range(1, 10);
      foreach (pm[i]) pm[i] = 0;
      last = '0;
      for (int j = 0; j < n; j++) begin
        off = $urandom_range(0, NB - 1);
        v = 8'($urandom);
        a = (j == 0) ? mk(pg, off) : mk($urandom_range(0, NPG - 1), off);
        if (j > 0) idle($urandom_range(0, TW - 1));
        wr(a, v);
        pd[off] = v; pm[off] = 1; last = v;
      end
      idle(TC - 1);
      chk("R4 not busy one edge before close", {7'd0, busy_n}, 8'd1);
      idle(1);
      chk("R4 busy at close", {7'd0, busy_n}, 8'd0);
      for (int k = 0; k < 3; k++) begin
        rd(mk($urandom_range(0, NPG - 1), $urandom_range(0, NB - 1)), v);
        chk("R7 status byte msb and low bits", {v[7], 1'b0, v[5:0]}, {~last[7], 1'b0, last[5:0]});
        chk("R8 status bit 6 sequence", {7'd0, v[6]}, {7'd0, status_exp(last, k)[6]});
      end
      idle(TP - 4);
      chk("R5 busy on last program cycle", {7'd0, busy_n}, 8'd0);
      idle(1);
      chk("R5 busy released", {7'd0, busy_n}, 8'd1);
      for (int i = 0; i < NB; i++) begin
        if (pm[i]) begin
          mem_m[(pg << OW) | i] = pd[i];
          known_m[(pg << OW) | i] = 1;
        end
      end
      for (int i = 0; i < NB; i++)
        check_known(pm[i] ? "R6 loaded slot" : "R6 unloaded slot kept", (pg << OW) | i);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule